// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver with Idle and Break Classification

This block receives asynchronous serial frames on a single input line. Before any sampling, the line passes through a two-flop synchroniser. An internal prescaler produces a sampling tick at sixteen times the bit rate. This prescaler belongs to the receiver alone, so the bit rate on the receive side can be set without reference to any transmitter.

A frame has these parts, in this order:
- a low start bit;
- eight or nine data bits, sent least significant bit first;
- a high stop bit.

When parity is enabled, the final data position carries the parity bit. Each completed frame produces a one-cycle valid strobe. The strobe comes with the received word and with framing-error and parity-error qualifiers.

The receiver also reports two line conditions that carry no data, each as its own one-cycle pulse:
- **Idle:** the line has stayed high for a whole frame time while the receiver waits for a start bit.
- **Break:** a complete frame, stop position included, was received as all zeros.

After a break, or any low stop bit, the receiver stays quiet until the line returns high. It then arms for the next start bit.

Top module: `serial_frame_rx`

## Requirements
- R1: With `wordNine`=0, a frame of eight data bits sent LSB first appears on `rxData[7:0]` with `rxData[8]`=0. It comes with a `rxValid` pulse one clock long, issued at the middle of the stop bit.
- R2: With `wordNine`=1, nine data bits are received LSB first and appear on `rxData[8:0]`.
- R3: A low pulse on `rxLine` shorter than half a bit time is rejected at the start-bit mid-point and produces no `rxValid`.
- R4: A stop bit sampled low, in a frame whose data bits are not all zero, still delivers the word with `rxValid`, and raises `frameErr` together with it.
- R5: With `parityOn`=1, the last data position (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is the parity bit and is included in `rxData`. `parityErr` is raised with `rxValid` when the XOR of all received data bits differs from `parityOdd` (0 = even, 1 = odd).
- R6: With `parityOn`=0, `parityErr` stays 0 whatever the data.
- R7: While the receiver waits for a start bit, a high line lasting 16×(data bits + 2) ticks gives exactly one `idleSeen` pulse. No further pulse follows until the line has gone low.
- R8: A frame received as all zeros with a low stop bit gives one `breakSeen` pulse and no `rxValid`.
- R9: After a low stop bit, whether a break or a framing error, no new frame starts while the line remains low. Once the line is high again, the next frame is received normally.
- R10: The sampling tick occurs every `baudDiv`+1 clocks, so one bit lasts 16×(`baudDiv`+1) clocks. Frames are received correctly at any such setting.
- R11: After reset, `rxValid`, `frameErr`, `parityErr`, `idleSeen`, `breakSeen` and `rxData` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Asynchronous serial input |
| baudDiv | input | DIV_W | Prescaler setting: one tick every baudDiv+1 clocks |
| wordNine | input | 1 | 1 selects nine data bits, 0 selects eight |
| parityOn | input | 1 | Last data position is a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| rxData | output | DATA_MAX | Received word, held until the next frame |
| rxValid | output | 1 | One-cycle strobe for a received word |
| frameErr | output | 1 | Stop bit was low; valid with rxValid |
| parityErr | output | 1 | Parity mismatch; valid with rxValid |
| idleSeen | output | 1 | One-cycle pulse for a full idle frame |
| breakSeen | output | 1 | One-cycle pulse for an all-zero frame |

## Verification
The hardest state to reach from the ports is the hold state after a low stop bit. A low stop bit in a frame that carries data looks like a break, or like a new start bit, depending on how long the line stays low. To get there, the stimulus builds frames bit by bit, chooses the stop bit's level on purpose, and keeps the line low for several bit times after the frame. It checks that nothing is delivered during that time, and that a normal frame sent after the line returns high is received intact. A companion test aims at the idle counter. It first clears the counter with a frame, then checks the pulse count before and after the frame-length window, and again well after it.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD
  } rxState_t;

  typedef struct packed {
    logic startFrame;
    logic sampleBit;
    logic commit;
    logic flagBreak;
    logic flagIdle;
  } rxStrobes_t;

endpackage

// File: rtl/frame_rx_baud.sv
module frame_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  output logic             tick
);

  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      tick   <= 1'b0;
    end else if (divCnt >= baudDiv) begin
      divCnt <= '0;
      tick   <= 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
      tick   <= 1'b0;
    end
  end

endmodule

// File: rtl/frame_rx_datapath.sv
module frame_rx_datapath
  import frame_rx_pkg::*;
#(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  rxStrobes_t          stb,
  input  logic                wordNine,
  input  logic                parityOn,
  input  logic                parityOdd,
  output logic                lineS,
  output logic                allZero,
  output logic [DATA_MAX-1:0] rxData,
  output logic                rxValid,
  output logic                frameErr,
  output logic                parityErr,
  output logic                idleSeen,
  output logic                breakSeen
);

  logic                syncMeta;
  logic [DATA_MAX-1:0] shiftReg;
  logic                zeroAcc;
  logic                parAcc;

  // two-flop synchroniser, reset to the idle (high) level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= 1'b1;
      lineS    <= 1'b1;
    end else begin
      syncMeta <= rxLine;
      lineS    <= syncMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      zeroAcc  <= 1'b1;
      parAcc   <= 1'b0;
    end else if (stb.startFrame) begin
      shiftReg <= '0;
      zeroAcc  <= 1'b1;
      parAcc   <= 1'b0;
    end else if (stb.sampleBit) begin
      shiftReg <= {lineS, shiftReg[DATA_MAX-1:1]};
      zeroAcc  <= zeroAcc & ~lineS;
      parAcc   <= parAcc ^ lineS;
    end
  end

  assign allZero = zeroAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxValid   <= 1'b0;
      frameErr  <= 1'b0;
      parityErr <= 1'b0;
      idleSeen  <= 1'b0;
      breakSeen <= 1'b0;
    end else begin
      rxValid   <= stb.commit;
      frameErr  <= stb.commit & ~lineS;
      parityErr <= stb.commit & parityOn & (parAcc != parityOdd);
      idleSeen  <= stb.flagIdle;
      breakSeen <= stb.flagBreak;
      if (stb.commit) begin
        rxData <= wordNine ? shiftReg : {1'b0, shiftReg[DATA_MAX-1:1]};
      end
    end
  end

endmodule

// File: rtl/frame_rx_control.sv
module frame_rx_control
  import frame_rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DATA_MAX = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       lineS,
  input  logic       allZero,
  input  logic       wordNine,
  output rxStrobes_t stb
);

  localparam int SUB_W  = $clog2(OVS);
  localparam int BIT_W  = $clog2(DATA_MAX + 1);
  localparam int IDLE_W = $clog2(OVS * (DATA_MAX + 2) + 1);
  localparam logic [SUB_W-1:0] MID_CNT = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] END_CNT = SUB_W'(OVS - 1);

  rxState_t          state;
  logic [SUB_W-1:0]  subCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic [BIT_W-1:0]  nBits;
  logic [IDLE_W-1:0] idleLimit;
  logic              midStart;
  logic              bitEnd;
  logic              stopPoint;

  assign nBits     = wordNine ? BIT_W'(DATA_MAX) : BIT_W'(DATA_MAX - 1);
  assign idleLimit = IDLE_W'(OVS) * (IDLE_W'(nBits) + IDLE_W'(2));
  assign midStart  = (state == ST_START) && tick && (subCnt == MID_CNT);
  assign bitEnd    = tick && (subCnt == END_CNT);
  assign stopPoint = (state == ST_STOP) && bitEnd;

  always_comb begin
    stb            = '0;
    stb.startFrame = midStart && !lineS;
    stb.sampleBit  = (state == ST_DATA) && bitEnd;
    stb.commit     = stopPoint && !(!lineS && allZero);
    stb.flagBreak  = stopPoint && !lineS && allZero;
    stb.flagIdle   = (state == ST_HUNT) && tick && lineS &&
                     (idleCnt == idleLimit - IDLE_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      subCnt  <= '0;
      bitCnt  <= '0;
      idleCnt <= '0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (tick) begin
            if (!lineS) begin
              state   <= ST_START;
              subCnt  <= '0;
              idleCnt <= '0;
            end else if (idleCnt != idleLimit) begin
              idleCnt <= idleCnt + 1'b1;
            end
          end
        end
        ST_START: begin
          if (midStart) begin
            subCnt <= '0;
            bitCnt <= '0;
            state  <= lineS ? ST_HUNT : ST_DATA;
          end else if (tick) begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            subCnt <= '0;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == nBits - BIT_W'(1)) state <= ST_STOP;
          end else if (tick) begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bitEnd) begin
            subCnt  <= '0;
            idleCnt <= '0;
            state   <= lineS ? ST_HUNT : ST_HOLD;
          end else if (tick) begin
            subCnt <= subCnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (tick && lineS) begin
            idleCnt <= '0;
            state   <= ST_HUNT;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import frame_rx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OVS      = 16,
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  logic [DIV_W-1:0]    baudDiv,
  input  logic                wordNine,
  input  logic                parityOn,
  input  logic                parityOdd,
  output logic [DATA_MAX-1:0] rxData,
  output logic                rxValid,
  output logic                frameErr,
  output logic                parityErr,
  output logic                idleSeen,
  output logic                breakSeen
);

  logic       tick;
  logic       lineS;
  logic       allZero;
  rxStrobes_t stb;

  frame_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .tick(tick)
  );

  frame_rx_control #(.OVS(OVS), .DATA_MAX(DATA_MAX)) u_ctl (
    .clk(clk), .rstN(rstN), .tick(tick), .lineS(lineS),
    .allZero(allZero), .wordNine(wordNine), .stb(stb)
  );

  frame_rx_datapath #(.DATA_MAX(DATA_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .stb(stb),
    .wordNine(wordNine), .parityOn(parityOn), .parityOdd(parityOdd),
    .lineS(lineS), .allZero(allZero), .rxData(rxData),
    .rxValid(rxValid), .frameErr(frameErr), .parityErr(parityErr),
    .idleSeen(idleSeen), .breakSeen(breakSeen)
  );

endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk #(
  parameter int DATA_MAX = 9
) (
  input logic                clk,
  input logic                rstN,
  input logic                wordNine,
  input logic                parityOn,
  input logic [DATA_MAX-1:0] rxData,
  input logic                rxValid,
  input logic                frameErr,
  input logic                parityErr,
  input logic                idleSeen,
  input logic                breakSeen
);

  p_valid_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_short_top_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !wordNine) |-> (rxData[DATA_MAX-1] == 1'b0));

  p_ferr_with_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> rxValid);

  p_perr_with_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> rxValid);

  p_no_parity_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parityOn && $stable(parityOn)) |-> !parityErr);

  p_idle_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    idleSeen |=> !idleSeen);

  p_break_alone_r8: assert property (@(posedge clk) disable iff (!rstN)
    breakSeen |-> (!rxValid && !idleSeen));

  p_break_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    breakSeen |=> !rxValid);

endmodule

bind serial_frame_rx serial_frame_rx_chk #(.DATA_MAX(DATA_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .wordNine(wordNine), .parityOn(parityOn),
  .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr),
  .parityErr(parityErr), .idleSeen(idleSeen), .breakSeen(breakSeen)
);

// File: tb/tb_serial_frame_rx.sv
module tb_serial_frame_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [15:0] baudDiv = 16'd3;
  logic        wordNine = 1'b0;
  logic        parityOn = 1'b0;
  logic        parityOdd = 1'b0;
  logic [8:0]  rxData;
  logic        rxValid, frameErr, parityErr, idleSeen, breakSeen;

  int total = 0;
  int bad = 0;
  int bitClk = 64;
  int vCnt = 0, bCnt = 0, iCnt = 0;
  logic [8:0] lastData = '0;
  logic lastFerr = 1'b0, lastPerr = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_frame_rx dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .baudDiv(baudDiv),
    .wordNine(wordNine), .parityOn(parityOn), .parityOdd(parityOdd),
    .rxData(rxData), .rxValid(rxValid), .frameErr(frameErr),
    .parityErr(parityErr), .idleSeen(idleSeen), .breakSeen(breakSeen)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        vCnt++;
        lastData = rxData;
        lastFerr = frameErr;
        lastPerr = parityErr;
      end
      if (breakSeen) bCnt++;
      if (idleSeen) iCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearCounts();
    vCnt = 0; bCnt = 0; iCnt = 0;
  endtask

  task automatic waitBits(input int n);
    repeat (n * bitClk) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] data, input int nData, input logic stopBit);
    logic [10:0] frame;
    frame = '0;
    for (int i = 0; i < nData; i++) frame[i+1] = data[i];
    frame[nData+1] = stopBit;
    for (int i = 0; i < nData + 2; i++) begin
      rxLine = frame[i];
      repeat (bitClk) @(negedge clk);
    end
    rxLine = 1'b1;
  endtask

  task automatic expectWord(input logic [8:0] d, input int nData, input string req);
    clearCounts();
    sendFrame(d, nData, 1'b1);
    waitBits(2);
    check(vCnt == 1, req, vCnt, 1);
    check(lastData == d, req, lastData, d);
    check(!lastFerr, req, lastFerr, 0);
  endtask

  task automatic t_reset();
    check(rxValid == 0 && frameErr == 0 && parityErr == 0, "R11", rxValid, 0);
    check(idleSeen == 0 && breakSeen == 0, "R11", breakSeen, 0);
    check(rxData == 0, "R11", rxData, 0);
  endtask

  task automatic t_eight();
    wordNine = 1'b0;
    expectWord(9'h0A5, 8, "R1");
    expectWord(9'h03C, 8, "R1");
  endtask

  task automatic t_nine();
    wordNine = 1'b1;
    expectWord(9'h1C3, 9, "R2");
    expectWord(9'h0F0, 9, "R2");
    wordNine = 1'b0;
  endtask

  task automatic t_glitch();
    clearCounts();
    rxLine = 1'b0;
    repeat (bitClk / 4) @(negedge clk);
    rxLine = 1'b1;
    waitBits(2);
    check(vCnt == 0, "R3 glitch", vCnt, 0);
    expectWord(9'h05A, 8, "R3 recover");
  endtask

  task automatic t_framing();
    clearCounts();
    sendFrame(9'h081, 8, 1'b0);
    waitBits(2);
    check(vCnt == 1, "R4", vCnt, 1);
    check(lastData == 9'h081, "R4", lastData, 9'h081);
    check(lastFerr, "R4", lastFerr, 1);
    check(bCnt == 0, "R4 no break", bCnt, 0);
  endtask

  task automatic t_parity();
    parityOn = 1'b1; parityOdd = 1'b0;
    clearCounts(); sendFrame(9'h035, 8, 1'b1); waitBits(2);
    check(vCnt == 1 && !lastPerr, "R5 even ok", lastPerr, 0);
    clearCounts(); sendFrame(9'h0B5, 8, 1'b1); waitBits(2);
    check(vCnt == 1 && lastPerr, "R5 even bad", lastPerr, 1);
    check(lastData == 9'h0B5, "R5 data", lastData, 9'h0B5);
    parityOdd = 1'b1;
    clearCounts(); sendFrame(9'h0B5, 8, 1'b1); waitBits(2);
    check(vCnt == 1 && !lastPerr, "R5 odd ok", lastPerr, 0);
    parityOdd = 1'b0; wordNine = 1'b1;
    clearCounts(); sendFrame(9'h0FF, 9, 1'b1); waitBits(2);
    check(vCnt == 1 && !lastPerr, "R5 nine ok", lastPerr, 0);
    clearCounts(); sendFrame(9'h1FF, 9, 1'b1); waitBits(2);
    check(vCnt == 1 && lastPerr, "R5 nine bad", lastPerr, 1);
    wordNine = 1'b0; parityOn = 1'b0;
    clearCounts(); sendFrame(9'h0B5, 8, 1'b1); waitBits(2);
    check(vCnt == 1 && !lastPerr, "R6", lastPerr, 0);
  endtask

  task automatic t_idle();
    sendFrame(9'h011, 8, 1'b1);
    clearCounts();
    waitBits(8);
    check(iCnt == 0, "R7 early", iCnt, 0);
    waitBits(4);
    check(iCnt == 1, "R7 once", iCnt, 1);
    waitBits(12);
    check(iCnt == 1, "R7 no repeat", iCnt, 1);
  endtask

  task automatic t_break();
    clearCounts();
    rxLine = 1'b0;
    waitBits(10);
    waitBits(6);
    check(bCnt == 1, "R8", bCnt, 1);
    check(vCnt == 0, "R8 no data", vCnt, 0);
    waitBits(12);
    check(vCnt == 0 && bCnt == 1, "R9 quiet", vCnt + bCnt, 1);
    rxLine = 1'b1;
    waitBits(1);
    expectWord(9'h066, 8, "R9 resume");
  endtask

  task automatic t_rate();
    baudDiv = 16'd1;
    bitClk = 32;
    waitBits(2);
    expectWord(9'h099, 8, "R10");
    baudDiv = 16'd3;
    bitClk = 64;
    waitBits(2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    waitBits(1);
    t_eight();
    t_nine();
    t_glitch();
    t_framing();
    t_parity();
    t_idle();
    t_break();
    t_rate();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule